// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside a NAND flash data path and watches every byte or halfword that crosses it. Over the data area of one page it builds a line/column Hamming parity in a single step. For each set data bit, every bit of the word index and every bit of the bit-within-word index chooses whether that bit goes into a parity bit or into its complement. After a program pass, software reads the two 16-bit parity registers and stores the four resulting ECC bytes in the spare area.

On a read pass the stored ECC bytes must follow the page data directly. On the final ECC word the engine forms the syndrome and classifies it. The result is one of four: clean, one flipped bit inside the stored code, one flipped data bit, or an uncorrectable pattern. For a data error it returns a word-plus-bit locator, which software uses to flip the bad bit in memory. A freshly erased page (all ones, including the ECC) yields the multiple-error flag and an all-ones locator, which software recognises as clean.

The sequencer has three states. ST_DATA accumulates page words. ST_ECC collects the stored code. ST_DONE ignores further words. Transition T_DATA_END moves ST_DATA to ST_ECC on the last data word. T_ECC_END moves ST_ECC to ST_DONE on the last ECC word. T_RESTART returns any state to ST_DATA when software issues a restart.

Top module: `nand_hecc`

## Requirements
- R1: The mode register (address 1) holds the page-size code in bits [1:0] and the bus width in bit [2] (1 = 16-bit). Codes 0..3 give 512, 1024, 2048 and 4096 data bytes, which is 528, 1056, 2112 or 4224 bytes with spare. The data words per page are bytes/2 on a 16-bit bus and bytes on an 8-bit bus, and are followed by 2 halfwords or 4 bytes of ECC. Writes to the mode register read back unchanged.
- R2: The parity register (address 3) holds the true-sense bits {word-index bits in [15:4], bit-index bits in [3:0]}. The complement register (address 4) holds the complement-sense bits in the same layout. Bits for index positions that the mode does not use read 0, and bit [3] is unused on an 8-bit bus.
- R3: Writing 1 to bit 0 of the control register (address 0) clears both parity registers and the status, and restarts the page at word 0.
- R4: Stored ECC is taken little-endian: ECC bytes 0..1 form the parity word and bytes 2..3 form the complement word. The status register (address 2) does not change before the final ECC word arrives.
- R5: A read with a zero syndrome leaves the status at 0, and the parity register shows the computed parity.
- R6: A single flipped data bit sets only status bit 0 (error seen). The parity register then reads {word index, bit offset}.
- R7: A single flipped bit in the stored ECC sets status bits 0 and 1 (code error), and never together with bit 2.
- R8: Any other non-zero syndrome sets status bits 0 and 2 (multiple error), and the parity register reads all ones.
- R9: A page and ECC that are entirely ones produce status bits 0 and 2 and a parity register of 16'hFFFF.
- R10: Words after the final ECC word change neither the status nor the parity register until a restart.
- R11: After reset the mode, status and both parity registers read 0.
- R12: On a 16-bit bus the locator counts halfwords and the bit offset spans 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 mode, 2 status, 3 parity, 4 complement) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| snp_valid | input | 1 | A page word is on the snooped bus this cycle |
| snp_read | input | 1 | 1 = word comes from the flash (read page), 0 = program page |
| snp_data | input | 16 | Snooped word; only bits [7:0] count on an 8-bit bus |

## Verification
The bench builds the engine with its default parameters: 16-bit lanes, a 12-bit word index, a 4-bit bit index and a 512-byte base page. With these values all four page sizes on both bus widths are reachable. The 4096-byte narrow page drives the locator to its full 12-bit word index, including the last word, 4095. The 16-bit modes exercise bit offsets above 7 and the halfword ECC order.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_ECC  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        VERDICT_CLEAN    = 2'd0,
        VERDICT_CODE_BIT = 2'd1,
        VERDICT_DATA_BIT = 2'd2,
        VERDICT_MULTI    = 2'd3
    } verdict_e;

    typedef struct packed {
        logic multi;
        logic code_bit;
        logic any_err;
    } ecc_stat_t;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] REG_MODE = 3'd1;
    localparam logic [REG_AW-1:0] REG_STAT = 3'd2;
    localparam logic [REG_AW-1:0] REG_PAR  = 3'd3;
    localparam logic [REG_AW-1:0] REG_NPAR = 3'd4;

endpackage

// File: rtl/ecc_seq.sv
module ecc_seq
    import nand_hecc_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SLOT_W      = 2,
    parameter int LAST_NARROW = 3,
    parameter int LAST_WIDE   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              strobe,
    input  logic              wide,
    input  logic [CNT_W-1:0]  last_data,
    output seq_state_e        state_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              acc_en,
    output logic              code_en,
    output logic              final_o
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             data_end;
    logic             code_end;

    assign data_end = cnt_q >= last_data;
    assign code_end = wide ? (cnt_q[SLOT_W-1:0] == SLOT_W'(LAST_WIDE))
                           : (cnt_q[SLOT_W-1:0] == SLOT_W'(LAST_NARROW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DATA;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = ST_DATA;
        end else begin
            unique case (state_q)
                ST_DATA: if (strobe && data_end) state_d = ST_ECC;
                ST_ECC:  if (strobe && code_end) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_DATA;
            endcase
        end
    end

    always_comb begin
        acc_en  = 1'b0;
        code_en = 1'b0;
        final_o = 1'b0;
        if (!restart && strobe) begin
            unique case (state_q)
                ST_DATA: acc_en = 1'b1;
                ST_ECC: begin
                    code_en = 1'b1;
                    final_o = code_end;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (acc_en) begin
            cnt_q <= data_end ? '0 : cnt_q + 1'b1;
        end else if (code_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign idx_o   = cnt_q;
    assign slot_o  = cnt_q[SLOT_W-1:0];

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
    parameter int DATA_W     = 16,
    parameter int WORD_IDX_W = 12,
    parameter int BIT_IDX_W  = 4,
    localparam int PAR_W     = WORD_IDX_W + BIT_IDX_W,
    localparam int HALF_W    = DATA_W / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  en,
    input  logic                  wide,
    input  logic [WORD_IDX_W-1:0] word_mask,
    input  logic [WORD_IDX_W-1:0] widx,
    input  logic [DATA_W-1:0]     data,
    output logic [PAR_W-1:0]      par_p,
    output logic [PAR_W-1:0]      par_n
);

    function automatic logic [DATA_W-1:0] col_sel(input int j);
        logic [DATA_W-1:0] s;
        s = '0;
        for (int k = 0; k < DATA_W; k++) begin
            s[k] = ((k >> j) & 1) == 1;
        end
        return s;
    endfunction

    logic [DATA_W-1:0]     dmask;
    logic                  word_par;
    logic [BIT_IDX_W-1:0]  col_p, col_n;
    logic [WORD_IDX_W-1:0] row_p, row_n;

    assign dmask    = wide ? data : {{HALF_W{1'b0}}, data[HALF_W-1:0]};
    assign word_par = ^dmask;

    // column parity: which half of each word's bit positions holds the ones
    for (genvar j = 0; j < BIT_IDX_W; j++) begin : g_col
        localparam logic [DATA_W-1:0] SEL = col_sel(j);
        logic col_used;
        assign col_used = wide || (j < BIT_IDX_W - 1);
        assign col_p[j] = col_used & (^(dmask & SEL));
        assign col_n[j] = col_used & (^(dmask & ~SEL));
    end

    // row parity: which half of the page's word indices holds the ones
    for (genvar i = 0; i < WORD_IDX_W; i++) begin : g_row
        assign row_p[i] = word_mask[i] &  widx[i] & word_par;
        assign row_n[i] = word_mask[i] & ~widx[i] & word_par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_p <= '0;
            par_n <= '0;
        end else if (clear) begin
            par_p <= '0;
            par_n <= '0;
        end else if (en) begin
            par_p <= par_p ^ {row_p, col_p};
            par_n <= par_n ^ {row_n, col_n};
        end
    end

endmodule

// File: rtl/ecc_judge.sv
module ecc_judge
    import nand_hecc_pkg::*;
#(
    parameter int PAR_W = 16
) (
    input  logic [PAR_W-1:0] comp_p,
    input  logic [PAR_W-1:0] comp_n,
    input  logic [PAR_W-1:0] stored_p,
    input  logic [PAR_W-1:0] stored_n,
    input  logic [PAR_W-1:0] valid,
    output logic [PAR_W-1:0] syn_p,
    output verdict_e         verdict
);

    logic [PAR_W-1:0]     syn_n;
    logic [$clog2(2*PAR_W+1)-1:0] ones;

    assign syn_p = (comp_p ^ stored_p) & valid;
    assign syn_n = (comp_n ^ stored_n) & valid;
    assign ones  = $bits(ones)'($countones({syn_p, syn_n}));

    always_comb begin
        if ({syn_p, syn_n} == '0) begin
            verdict = VERDICT_CLEAN;
        end else if (ones == 1) begin
            verdict = VERDICT_CODE_BIT;
        end else if ((syn_p ^ syn_n) == valid) begin
            verdict = VERDICT_DATA_BIT;
        end else begin
            verdict = VERDICT_MULTI;
        end
    end

endmodule

// File: rtl/nand_hecc.sv
module nand_hecc
    import nand_hecc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WORD_IDX_W = 12,
    parameter int BIT_IDX_W  = 4,
    parameter int BASE_LG    = 9,
    localparam int PAR_W     = WORD_IDX_W + BIT_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PAR_W-1:0]  reg_wdata,
    output logic [PAR_W-1:0]  reg_rdata,
    input  logic              snp_valid,
    input  logic              snp_read,
    input  logic [DATA_W-1:0] snp_data
);

    localparam int HALF_W      = DATA_W / 2;
    localparam int ECC_W       = 2 * PAR_W;
    localparam int SLOTS_NAR   = ECC_W / HALF_W;
    localparam int SLOTS_WIDE  = ECC_W / DATA_W;
    localparam int SLOT_W      = $clog2(SLOTS_NAR);

    logic [1:0]            size_q;
    logic                  wide_q;
    ecc_stat_t             stat_q;
    logic [PAR_W-1:0]      loc_q;
    logic                  show_loc_q;
    logic [ECC_W-1:0]      code_q, code_d;

    logic                  restart;
    logic                  chk_fire;
    int unsigned           lg_words;
    logic [WORD_IDX_W-1:0] word_mask;
    logic [WORD_IDX_W-1:0] last_data;
    logic [BIT_IDX_W-1:0]  bit_mask;
    logic [PAR_W-1:0]      valid;

    seq_state_e            state;
    logic [WORD_IDX_W-1:0] widx;
    logic [SLOT_W-1:0]     slot;
    logic                  acc_en, code_en, final_w;
    logic [PAR_W-1:0]      par_p, par_n, syn_p;
    verdict_e              verdict;

    assign restart  = reg_we && (reg_addr == REG_CTRL) && reg_wdata[0];

    always_comb begin
        lg_words = BASE_LG + 32'(size_q) - 32'(wide_q);
        for (int i = 0; i < WORD_IDX_W; i++) begin
            word_mask[i] = (i < lg_words);
        end
        last_data = WORD_IDX_W'((64'd1 << lg_words) - 64'd1);
        bit_mask  = wide_q ? '1 : {1'b0, {(BIT_IDX_W-1){1'b1}}};
        valid     = {word_mask, bit_mask};
    end

    ecc_seq #(
        .CNT_W      (WORD_IDX_W),
        .SLOT_W     (SLOT_W),
        .LAST_NARROW(SLOTS_NAR - 1),
        .LAST_WIDE  (SLOTS_WIDE - 1)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .strobe   (snp_valid),
        .wide     (wide_q),
        .last_data(last_data),
        .state_o  (state),
        .idx_o    (widx),
        .slot_o   (slot),
        .acc_en   (acc_en),
        .code_en  (code_en),
        .final_o  (final_w)
    );

    ecc_accum #(
        .DATA_W    (DATA_W),
        .WORD_IDX_W(WORD_IDX_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .en       (acc_en),
        .wide     (wide_q),
        .word_mask(word_mask),
        .widx     (widx),
        .data     (snp_data),
        .par_p    (par_p),
        .par_n    (par_n)
    );

    // stored code assembled little-endian, including the word on the bus now
    always_comb begin
        code_d = code_q;
        if (code_en) begin
            if (wide_q) begin
                code_d[32'(slot) * DATA_W +: DATA_W] = snp_data;
            end else begin
                code_d[32'(slot) * HALF_W +: HALF_W] = snp_data[HALF_W-1:0];
            end
        end
    end

    ecc_judge #(
        .PAR_W(PAR_W)
    ) i_judge (
        .comp_p  (par_p),
        .comp_n  (par_n),
        .stored_p(code_d[PAR_W-1:0]),
        .stored_n(code_d[ECC_W-1:PAR_W]),
        .valid   (valid),
        .syn_p   (syn_p),
        .verdict (verdict)
    );

    assign chk_fire = final_w && snp_read;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            wide_q <= 1'b0;
        end else if (reg_we && (reg_addr == REG_MODE)) begin
            size_q <= reg_wdata[1:0];
            wide_q <= reg_wdata[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= '0;
            stat_q     <= '0;
            loc_q      <= '0;
            show_loc_q <= 1'b0;
        end else if (restart) begin
            code_q     <= '0;
            stat_q     <= '0;
            loc_q      <= '0;
            show_loc_q <= 1'b0;
        end else begin
            code_q <= code_d;
            if (chk_fire) begin
                unique case (verdict)
                    VERDICT_CLEAN: begin
                        stat_q     <= '0;
                        show_loc_q <= 1'b0;
                    end
                    VERDICT_CODE_BIT: begin
                        stat_q     <= '{multi: 1'b0, code_bit: 1'b1, any_err: 1'b1};
                        show_loc_q <= 1'b0;
                    end
                    VERDICT_DATA_BIT: begin
                        stat_q     <= '{multi: 1'b0, code_bit: 1'b0, any_err: 1'b1};
                        loc_q      <= syn_p;
                        show_loc_q <= 1'b1;
                    end
                    VERDICT_MULTI: begin
                        stat_q     <= '{multi: 1'b1, code_bit: 1'b0, any_err: 1'b1};
                        loc_q      <= '1;
                        show_loc_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_MODE: reg_rdata = PAR_W'({wide_q, size_q});
            REG_STAT: reg_rdata = PAR_W'(stat_q);
            REG_PAR:  reg_rdata = show_loc_q ? loc_q : par_p;
            REG_NPAR: reg_rdata = par_n & valid;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nand_hecc_chk.sv
module nand_hecc_chk
    import nand_hecc_pkg::*;
#(
    parameter int PAR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              fire,
    input logic [2:0]        stat,
    input logic [PAR_W-1:0]  par_p,
    input logic [REG_AW-1:0] reg_addr,
    input logic [PAR_W-1:0]  reg_rdata
);

    // R8
    multi_sets_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2] |-> stat[0]);

    // R7
    code_not_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] |-> !stat[2]);

    // R4
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !restart) |=> $stable(stat));

    // R3
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (stat == 3'b000 && par_p == '0));

    // R8
    multi_locator_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[2] && reg_addr == REG_PAR) |-> (reg_rdata == '1));

endmodule

bind nand_hecc nand_hecc_chk #(.PAR_W(PAR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .fire     (chk_fire),
    .stat     (stat_q),
    .par_p    (par_p),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/test_nand_hecc.sv
module test_nand_hecc;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  size;
        logic        wide;
        logic [7:0]  seed;
        logic [2:0]  kind;   // 0 clean, 1 data bit, 2 code bit, 3 double, 4 erased
        logic [11:0] w1;
        logic [3:0]  b1;
        logic [11:0] w2;
        logic [3:0]  b2;
        logic [2:0]  stat;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 8'd3,  3'd0, 12'd0,    4'd0,  12'd0,  4'd0, 3'b000},
        '{2'd0, 1'b0, 8'd7,  3'd1, 12'd100,  4'd5,  12'd0,  4'd0, 3'b001},
        '{2'd1, 1'b1, 8'd11, 3'd1, 12'd300,  4'd13, 12'd0,  4'd0, 3'b001},
        '{2'd2, 1'b0, 8'd5,  3'd2, 12'd20,   4'd0,  12'd0,  4'd0, 3'b011},
        '{2'd1, 1'b0, 8'd9,  3'd3, 12'd10,   4'd1,  12'd20, 4'd6, 3'b101},
        '{2'd3, 1'b0, 8'd13, 3'd1, 12'd4095, 4'd7,  12'd0,  4'd0, 3'b001},
        '{2'd0, 1'b1, 8'd2,  3'd4, 12'd0,    4'd0,  12'd0,  4'd0, 3'b101},
        '{2'd3, 1'b1, 8'd17, 3'd1, 12'd0,    4'd0,  12'd0,  4'd0, 3'b001},
        '{2'd2, 1'b1, 8'd21, 3'd2, 12'd3,    4'd0,  12'd0,  4'd0, 3'b011},
        '{2'd0, 1'b0, 8'd1,  3'd4, 12'd0,    4'd0,  12'd0,  4'd0, 3'b101},
        '{2'd1, 1'b1, 8'd23, 3'd3, 12'd5,    4'd2,  12'd5,  4'd9, 3'b101}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        snp_valid = 1'b0;
    logic        snp_read = 1'b0;
    logic [15:0] snp_data = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] page [4096];
    logic [15:0] mp, mn, rv;
    logic [31:0] code;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_hecc i_nand_hecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .snp_valid(snp_valid),
        .snp_read (snp_read),
        .snp_data (snp_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_word(input logic [15:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_data = d;
    endtask

    task automatic go_idle();
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic fill(input int nw, input bit wide, input int seed, input bit ones);
        for (int w = 0; w < nw; w++) begin
            logic [15:0] v;
            v = 16'((w * 37 + seed * 101) ^ (w >> 3) ^ (seed << 9) ^ ((w * seed) << 5));
            if (ones) v = 16'hFFFF;
            page[w] = wide ? v : {8'h00, v[7:0]};
        end
    endtask

    // Parity per R2: true-sense bit when the index bit is 1, complement otherwise
    task automatic model(input int nw, input bit wide, input int lg);
        mp = '0; mn = '0;
        for (int w = 0; w < nw; w++) begin
            for (int k = 0; k < (wide ? 16 : 8); k++) begin
                if (page[w][k]) begin
                    for (int i = 0; i < lg; i++) begin
                        if (((w >> i) & 1) == 1) mp[4+i] = ~mp[4+i];
                        else                     mn[4+i] = ~mn[4+i];
                    end
                    for (int j = 0; j < (wide ? 4 : 3); j++) begin
                        if (((k >> j) & 1) == 1) mp[j] = ~mp[j];
                        else                     mn[j] = ~mn[j];
                    end
                end
            end
        end
    endtask

    task automatic stream(input int nw, input bit wide, input logic [31:0] c, input bit skip_last);
        int nc;
        for (int w = 0; w < nw; w++) send_word(page[w]);
        nc = wide ? 2 : 4;
        for (int s = 0; s < nc; s++) begin
            if (!(skip_last && s == nc - 1)) begin
                if (wide) send_word(c[16*s +: 16]);
                else      send_word({8'h00, c[8*s +: 8]});
            end
        end
        go_idle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values
        reg_read(3'd1, rv); check("R11 mode", rv, 16'h0000);
        reg_read(3'd2, rv); check("R11 status", rv, 16'h0000);
        reg_read(3'd3, rv); check("R11 parity", rv, 16'h0000);
        reg_read(3'd4, rv); check("R11 complement", rv, 16'h0000);

        // R1 mode readback
        reg_write(3'd1, 16'h0005);
        reg_read(3'd1, rv); check("R1 mode readback", rv, 16'h0005);

        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            int nw, lg;
            logic [15:0] exp_par;
            string tag;
            t  = VECS[v];
            nw = (512 << t.size) >> t.wide;
            lg = 9 + int'(t.size) - int'(t.wide);
            reg_write(3'd1, {13'd0, t.wide, t.size});
            reg_write(3'd0, 16'h0001);
            fill(nw, t.wide, int'(t.seed), t.kind == 3'd4);
            model(nw, t.wide, lg);
            // program pass
            snp_read = 1'b0;
            stream(nw, t.wide, {mn, mp}, 1'b0);
            reg_read(3'd3, rv); check("R2 parity", rv, mp);
            reg_read(3'd4, rv); check("R2 complement", rv, mn);
            // read pass with the chosen corruption
            reg_write(3'd0, 16'h0001);
            code = (t.kind == 3'd4) ? 32'hFFFF_FFFF : {mn, mp};
            if (t.kind == 3'd1 || t.kind == 3'd3) page[t.w1][t.b1] = ~page[t.w1][t.b1];
            if (t.kind == 3'd3) page[t.w2][t.b2] = ~page[t.w2][t.b2];
            if (t.kind == 3'd2) code[t.w1[4:0]] = ~code[t.w1[4:0]];
            snp_read = 1'b1;
            stream(nw, t.wide, code, 1'b0);
            snp_read = 1'b0;
            case (t.kind)
                3'd0: begin tag = "R5 clean";   exp_par = mp; end
                3'd1: begin tag = t.wide ? "R12 halfword locator" : "R6 data bit";
                            exp_par = {t.w1, t.b1}; end
                3'd2: begin tag = "R7 code bit"; exp_par = mp; end
                3'd3: begin tag = "R8 multiple"; exp_par = 16'hFFFF; end
                default: begin tag = "R9 erased"; exp_par = 16'hFFFF; end
            endcase
            reg_read(3'd2, rv); check({tag, " status"}, rv, {13'd0, t.stat});
            reg_read(3'd3, rv); check({tag, " parity"}, rv, exp_par);
        end

        // R4: status waits for the last code byte
        reg_write(3'd1, 16'h0000);
        reg_write(3'd0, 16'h0001);
        fill(512, 1'b0, 4, 1'b0);
        model(512, 1'b0, 9);
        page[3][2] = ~page[3][2];
        snp_read = 1'b1;
        stream(512, 1'b0, {mn, mp}, 1'b1);
        reg_read(3'd2, rv); check("R4 before final", rv, 16'h0000);
        send_word({8'h00, mn[15:8]});
        go_idle();
        reg_read(3'd2, rv); check("R4 after final", rv, 16'h0001);

        // R10: trailing words ignored
        for (int k = 0; k < 5; k++) send_word(16'h00A5 ^ 16'(k));
        go_idle();
        snp_read = 1'b0;
        reg_read(3'd2, rv); check("R10 status", rv, 16'h0001);
        reg_read(3'd3, rv); check("R10 parity", rv, {12'd3, 4'd2});

        // R3: restart clears status and parity, also mid-page
        reg_write(3'd0, 16'h0001);
        reg_read(3'd2, rv); check("R3 status", rv, 16'h0000);
        reg_read(3'd3, rv); check("R3 parity", rv, 16'h0000);
        for (int k = 0; k < 7; k++) send_word(16'h00FF);
        go_idle();
        reg_write(3'd0, 16'h0001);
        reg_read(3'd3, rv); check("R3 mid-page parity", rv, 16'h0000);
        reg_read(3'd4, rv); check("R3 mid-page complement", rv, 16'h0000);

        finish_run();
    end

endmodule